// File: doc/BRIEF.md
# Ones-Complement Checksum Generator and Checker

This block forms a 16-bit ones-complement checksum over a packet that arrives one octet per clock. Octets are grouped in pairs into 16-bit words, the first octet of a pair being the upper half. The words are added as unsigned numbers, and every carry out of bit 15 is folded back into bit 0. The same adder and accumulator serve both directions of use. A sender computes the value to place in a header. A receiver confirms that a header, including its transmitted checksum, sums to all ones.

Each octet comes with a valid strobe, a last-of-packet marker and a skip flag. A skipped octet still occupies its position in the word pairing but adds zero. A sender marks the two checksum octets as skipped, so their contents do not matter. A mode input, sampled together with the last octet, selects generate or check. One cycle after the last octet, the block presents the complement of the folded sum and, in check mode, a pass bit. The next octet after a last marker starts a new packet from a zero sum.

Top module: `ones_sum_engine`

## Requirements
- R1: Octets pair into words, the earlier octet of each pair in bits 15:8 and the later in bits 7:0, and the words are added as unsigned values.
- R2: Any carry out of bit 15 is added back into bit 0 (end-around carry), e.g. bytes FF FF 00 01 fold to 0001 and give result FFFE.
- R3: The result `resSum` is the bitwise complement of the folded sum; for the bytes 00 01 F2 03 F4 F5 F6 F7 (optionally followed by two skipped bytes) the result is 220D.
- R4: With `modeCheck`=1 on the last octet, `resPass` is 1 exactly when the folded sum equals FFFF, in which case `resSum` is 0000.
- R5: An octet with `byteSkip`=1 contributes zero but still counts as one position in the pairing; bytes 12 34(skipped) 56 78 give 9787.
- R6: If a packet has an odd number of octets, the final octet is the upper half of a word whose lower half is zero; bytes 12 34 56 give 97CB, and a single byte AB gives 54FF.
- R7: `resValid` is 1 in exactly the cycle after a cycle whose octet was accepted with `byteLast`=1, and 0 in every other cycle; `resSum` and `resPass` are valid in that cycle.
- R8: The sum restarts from zero with the first octet after a last marker, including when that octet follows in the very next cycle.
- R9: After reset `resValid`, `resPass` and `resSum` are all 0.
- R10: With `modeCheck`=0 on the last octet, `resPass` is 0.
- R11: Cycles with `byteValid`=0 have no effect, whatever `byteData`, `byteLast` and `byteSkip` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| byteValid | input | 1 | An octet is present this cycle |
| byteData | input | 8 | Octet value |
| byteLast | input | 1 | This octet ends the packet |
| byteSkip | input | 1 | Octet adds zero but keeps its position |
| modeCheck | input | 1 | 1 = check, 0 = generate; sampled with the last octet |
| resValid | output | 1 | One-cycle result strobe |
| resSum | output | 16 | Complement of the folded sum |
| resPass | output | 1 | Check mode: folded sum was all ones |

## Verification
The hardest condition to reach from the ports is a check-mode packet that truly sums to FFFF. Random octets almost never do that. The stimulus therefore first computes a checksum in the bench for random data and writes it into an even position of the packet, then sends the packet in check mode. Half of those packets also have a single random bit flipped, so both the pass and the fail outcomes occur. Back-to-back packets with no idle cycle between them, and idle cycles carrying random marker values, exercise the automatic restart of the sum.

// File: rtl/ones_sum_pkg.sv
package ones_sum_pkg;

  // Strobes sent from control to datapath each cycle
  typedef struct packed {
    logic loadHigh;   // store octet as upper half of pending word
    logic addPair;    // add pending upper half with this octet as lower half
    logic addPadded;  // add this octet as upper half, lower half zero
    logic freshStart; // this octet begins a packet: sum base is zero
    logic finish;     // this octet closes the packet
    logic maskByte;   // this octet contributes zero
  } ctrlStrobe_t;

endpackage

// File: rtl/ones_sum_add.sv
module ones_sum_add #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] folded,
  output logic             carryOut
);

  logic [WIDTH:0] rawSum;

  always_comb begin
    rawSum   = {1'b0, opA} + {1'b0, opB};
    carryOut = rawSum[WIDTH];
    // end-around carry: a second carry cannot arise
    folded   = rawSum[WIDTH-1:0] + {{(WIDTH-1){1'b0}}, rawSum[WIDTH]};
  end

endmodule

// File: rtl/ones_sum_ctrl.sv
module ones_sum_ctrl
  import ones_sum_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        byteValid,
  input  logic        byteLast,
  input  logic        byteSkip,
  output ctrlStrobe_t strb
);

  logic oddPos;   // next octet is the lower half of a word
  logic freshPkt; // next octet begins a packet

  always_comb begin
    strb.loadHigh   = byteValid && !oddPos && !byteLast;
    strb.addPair    = byteValid && oddPos;
    strb.addPadded  = byteValid && !oddPos && byteLast;
    strb.freshStart = freshPkt;
    strb.finish     = byteValid && byteLast;
    strb.maskByte   = byteSkip;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      oddPos   <= 1'b0;
      freshPkt <= 1'b1;
    end else if (byteValid) begin
      oddPos   <= byteLast ? 1'b0 : !oddPos;
      freshPkt <= byteLast;
    end
  end

  // R6 / R8: a last octet realigns pairing and arms the restart
  assert_realign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && byteLast) |=> (!oddPos && freshPkt));

  // R11: no octet, no change in pairing state
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |=> ($stable(oddPos) && $stable(freshPkt)));

endmodule

// File: rtl/ones_sum_dpath.sv
module ones_sum_dpath
  import ones_sum_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strb,
  input  logic [LANE_W-1:0]     byteData,
  input  logic                  modeCheck,
  output logic                  resValid,
  output logic [2*LANE_W-1:0]   resSum,
  output logic                  resPass
);

  localparam int WORD_W = 2 * LANE_W;

  logic [LANE_W-1:0] hiReg;
  logic [WORD_W-1:0] acc;
  logic [LANE_W-1:0] laneVal;
  logic [WORD_W-1:0] wordIn;
  logic [WORD_W-1:0] baseVal;
  logic [WORD_W-1:0] folded;
  logic              carryOut;
  logic              doAdd;

  always_comb begin
    laneVal = strb.maskByte ? '0 : byteData;
    wordIn  = strb.addPair ? {hiReg, laneVal} : {laneVal, {LANE_W{1'b0}}};
    baseVal = strb.freshStart ? '0 : acc;
    doAdd   = strb.addPair || strb.addPadded;
  end

  ones_sum_add #(.WIDTH(WORD_W)) uAdd (
    .opA      (baseVal),
    .opB      (wordIn),
    .folded   (folded),
    .carryOut (carryOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiReg <= '0;
      acc   <= '0;
    end else begin
      if (strb.loadHigh) begin
        hiReg <= laneVal;
        if (strb.freshStart) acc <= '0;
      end
      if (doAdd) acc <= folded;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid <= 1'b0;
      resSum   <= '0;
      resPass  <= 1'b0;
    end else begin
      resValid <= strb.finish;
      if (strb.finish) begin
        resSum  <= ~folded;
        resPass <= modeCheck && (&folded);
      end
    end
  end

  // R2: a wrapped carry never leaves a zero sum
  assert_wrap_nonzero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (doAdd && carryOut) |-> (folded != '0));

  // R7: result strobe follows the closing octet by exactly one cycle
  assert_result_timing_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> resValid);
  assert_result_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> !resValid);

  // R4: a pass always carries a zero complement
  assert_pass_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resPass) |-> (resSum == '0));

  // R10: generate mode never reports a pass
  assert_gen_nopass_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !modeCheck) |=> !resPass);

endmodule

// File: rtl/ones_sum_engine.sv
module ones_sum_engine
  import ones_sum_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                byteValid,
  input  logic [LANE_W-1:0]   byteData,
  input  logic                byteLast,
  input  logic                byteSkip,
  input  logic                modeCheck,
  output logic                resValid,
  output logic [2*LANE_W-1:0] resSum,
  output logic                resPass
);

  ctrlStrobe_t strb;

  ones_sum_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteLast  (byteLast),
    .byteSkip  (byteSkip),
    .strb      (strb)
  );

  ones_sum_dpath #(.LANE_W(LANE_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .byteData  (byteData),
    .modeCheck (modeCheck),
    .resValid  (resValid),
    .resSum    (resSum),
    .resPass   (resPass)
  );

endmodule

// File: tb/tb_ones_sum_engine.sv
`timescale 1ns/1ps
module tb_ones_sum_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        byteValid;
  logic [7:0]  byteData;
  logic        byteLast;
  logic        byteSkip;
  logic        modeCheck;
  logic        resValid;
  logic [15:0] resSum;
  logic        resPass;

  always #2.5 clk = ~clk;

  ones_sum_engine dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .byteLast(byteLast), .byteSkip(byteSkip), .modeCheck(modeCheck),
    .resValid(resValid), .resSum(resSum), .resPass(resPass)
  );

  typedef struct {
    logic [15:0] sum;
    logic        pass;
    string       req;
  } expect_t;

  int checks = 0;
  int fails  = 0;
  expect_t expQ[$];
  logic [7:0] pData [64];
  logic       pSkip [64];
  logic sawLast;
  logic sawIdleLast;
  bit   monOn = 1'b0;
  bit   done  = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // reference fold of the current packet buffer
  function automatic logic [15:0] refFold(input int n);
    logic [16:0] a = '0;
    for (int i = 0; i < n; i += 2) begin
      logic [7:0] hi = pSkip[i] ? 8'h00 : pData[i];
      logic [7:0] lo = (i + 1 < n) ? (pSkip[i+1] ? 8'h00 : pData[i+1]) : 8'h00;
      a = {1'b0, a[15:0]} + {1'b0, hi, lo};
      a = {1'b0, a[15:0]} + {16'h0, a[16]};
    end
    return a[15:0];
  endfunction

  // monitor: inputs seen at the edge, outputs compared at the next negedge
  always @(posedge clk) begin
    sawLast     <= rstN && byteValid && byteLast;
    sawIdleLast <= rstN && !byteValid && byteLast;
  end

  always @(negedge clk) begin
    if (monOn) begin
      if (sawLast) begin
        expect_t e;
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "no expected entry", 32'(resValid), 32'd1);
        end else begin
          e = expQ.pop_front();
          check(resValid === 1'b1, "R7", "resValid after last", 32'(resValid), 32'd1);
          check(resSum === e.sum, e.req, "resSum", 32'(resSum), 32'(e.sum));
          check(resPass === e.pass, e.req, "resPass", 32'(resPass), 32'(e.pass));
        end
      end else begin
        check(resValid === 1'b0, sawIdleLast ? "R11" : "R7", "resValid quiet",
              32'(resValid), 32'd0);
      end
    end
  end

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      byteValid = 1'b0;
      byteData  = 8'($urandom);
      byteLast  = 1'($urandom);
      byteSkip  = 1'($urandom);
      modeCheck = 1'($urandom);
    end
  endtask

  // send the buffer as one packet; last octet pushes the expectation
  task automatic sendPkt(input int n, input bit mode, input int gapMax,
                         input string req, input bit fixOn,
                         input logic [15:0] fixSum, input bit fixPass);
    expect_t e;
    logic [15:0] f;
    f = refFold(n);
    e.sum  = fixOn ? fixSum  : ~f;
    e.pass = fixOn ? fixPass : (mode && f == 16'hFFFF);
    e.req  = req;
    for (int i = 0; i < n; i++) begin
      if (gapMax > 0) idle($urandom % (gapMax + 1));
      @(negedge clk);
      byteValid = 1'b1;
      byteData  = pData[i];
      byteSkip  = pSkip[i];
      byteLast  = (i == n - 1);
      modeCheck = (i == n - 1) ? mode : 1'($urandom);
      if (i == n - 1) expQ.push_back(e);
    end
  endtask

  task automatic load(input int n, input logic [63:0] bytesMsb, input logic [7:0] skips);
    for (int i = 0; i < 64; i++) begin
      pData[i] = 8'h00;
      pSkip[i] = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      pData[i] = bytesMsb[63 - 8*i -: 8];
      pSkip[i] = skips[7 - i];
    end
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; byteValid = 1'b0; byteData = '0; byteLast = 1'b0;
    byteSkip = 1'b0; modeCheck = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(resValid === 1'b0, "R9", "resValid", 32'(resValid), 32'd0);
    check(resSum === 16'h0, "R9", "resSum", 32'(resSum), 32'd0);
    check(resPass === 1'b0, "R9", "resPass", 32'(resPass), 32'd0);
    monOn = 1'b1;

    // R3 / R1: worked example, generate mode, checksum field skipped
    load(8, 64'h0001F203F4F5F6F7, 8'h00);
    sendPkt(8, 1'b0, 0, "R3", 1'b1, 16'h220D, 1'b0);
    idle(2);
    for (int i = 0; i < 64; i++) begin pData[i] = 8'h00; pSkip[i] = 1'b0; end
    pData[0] = 8'h00; pData[1] = 8'h01; pData[2] = 8'hF2; pData[3] = 8'h03;
    pData[4] = 8'hF4; pData[5] = 8'hF5; pData[6] = 8'hF6; pData[7] = 8'hF7;
    pData[8] = 8'h5A; pData[9] = 8'hA5; pSkip[8] = 1'b1; pSkip[9] = 1'b1;
    sendPkt(10, 1'b0, 1, "R3", 1'b1, 16'h220D, 1'b0);
    idle(1);
    // R4: same header with its checksum, check mode passes
    pData[8] = 8'h22; pData[9] = 8'h0D; pSkip[8] = 1'b0; pSkip[9] = 1'b0;
    sendPkt(10, 1'b1, 0, "R4", 1'b1, 16'h0000, 1'b1);
    idle(1);
    // R4: corrupted checksum fails
    pData[9] = 8'h0C;
    sendPkt(10, 1'b1, 0, "R4", 1'b1, 16'h0001, 1'b0);
    idle(1);
    // R10: valid header in generate mode never passes
    pData[9] = 8'h0D;
    sendPkt(10, 1'b0, 0, "R10", 1'b1, 16'h0000, 1'b0);
    idle(1);
    // R2: end-around carry
    load(4, 64'hFFFF0001_00000000, 8'h00);
    sendPkt(4, 1'b0, 0, "R2", 1'b1, 16'hFFFE, 1'b0);
    idle(1);
    // R6: odd lengths
    load(3, 64'h123456_0000000000, 8'h00);
    sendPkt(3, 1'b0, 0, "R6", 1'b1, 16'h97CB, 1'b0);
    load(1, 64'hAB_00000000000000, 8'h00);
    sendPkt(1, 1'b0, 0, "R6", 1'b1, 16'h54FF, 1'b0);
    // R5: skipped octet keeps its position
    load(4, 64'h12345678_00000000, 8'b0100_0000);
    sendPkt(4, 1'b0, 2, "R5", 1'b1, 16'h9787, 1'b0);
    // R8: back to back, no idle between packets
    load(3, 64'hFFFFFF_0000000000, 8'h00);
    sendPkt(3, 1'b0, 0, "R8", 1'b1, 16'h00FF, 1'b0);
    load(2, 64'h0102_000000000000, 8'h00);
    sendPkt(2, 1'b0, 0, "R8", 1'b1, 16'hFEFD, 1'b0);
    // R11: idle junk between bytes of a packet
    idle(5);
    load(4, 64'h0A0B0C0D_00000000, 8'h00);
    sendPkt(4, 1'b0, 2, "R11", 1'b1, 16'hE9E7, 1'b0);
    idle(3);

    // random packets, both modes
    for (int k = 0; k < 300; k++) begin
      int n = 1 + int'($urandom % 40);
      bit mode = 1'($urandom);
      for (int i = 0; i < 64; i++) begin
        pData[i] = 8'($urandom);
        pSkip[i] = mode ? 1'b0 : (($urandom % 8) == 0);
      end
      if (mode && n >= 2) begin
        int p = 2 * int'($urandom % (n / 2));
        logic [15:0] c;
        pSkip[p] = 1'b1; pSkip[p+1] = 1'b1;
        c = ~refFold(n);
        pData[p] = c[15:8]; pData[p+1] = c[7:0];
        pSkip[p] = 1'b0; pSkip[p+1] = 1'b0;
        if ($urandom % 2 == 1) begin
          int q = int'($urandom % n);
          pData[q] = pData[q] ^ (8'h01 << ($urandom % 8));
        end
      end
      sendPkt(n, mode, (k % 3 == 0) ? 0 : 2, mode ? "R4" : "R1", 1'b0, 16'h0, 1'b0);
      if ($urandom % 2 == 1) idle(1 + int'($urandom % 3));
    end
    idle(3);
    finishRun();
  end

endmodule